// File: doc/BRIEF.md
# Byte-Order-Selectable Aligned Load/Store Lane Unit

This block sits between a processor's load/store path and a memory organised as four 8-bit byte lanes behind a 32-bit data bus. Each request carries a byte address, an access size (byte, halfword or word), a read/write flag, store data and a sign-extension choice for narrow loads. A configuration bit picks the byte order. When the bit is 0, the lowest byte address holds the least significant byte of a value. When it is 1, the lowest byte address holds the most significant byte.

For an aligned request, the block drives a word address, per-lane byte enables and lane-steered write data to the memory in the same cycle the request is accepted. On a load, it collects the lanes that the memory returns on the following cycle into a right-justified result. A misaligned request never reaches the memory. It is answered with an error pulse instead.

Top module: `endian_access_unit`

## Requirements
- R1: An accepted aligned request drives `mem_en` high and sets `mem_addr` to the byte address shifted right by two. The memory data bus has lane k on bits [8k+7:8k]. With the order bit at 0, byte-address offset j within a word travels on lane j. With the order bit at 1, it travels on lane 3-j.
- R2: With `cfg_big_end`=0, byte i of a value (byte 0 being least significant) is stored to and loaded from byte address A+i, where A is the request address.
- R3: With `cfg_big_end`=1, byte i of an n-byte value is stored to and loaded from byte address A+n-1-i.
- R4: A halfword access (`req_size`=01) is aligned only when address bit 0 is 0.
- R5: A word access (`req_size`=10) is aligned only when address bits [1:0] are 00. A byte access (`req_size`=00) is always aligned.
- R6: A misaligned request drives `mem_en` low and `mem_be` to zero. It leaves memory contents unchanged and raises `rsp_err` in its response cycle.
- R7: On an aligned load, `rsp_data` holds the value right-justified. It is zero-extended when `req_sext`=0 and sign-extended from the value's top bit when `req_sext`=1. `rsp_data` is zero for stores and for errors.
- R8: Loads never write: `mem_we` is high only for an accepted aligned store, and a load leaves memory contents unchanged.
- R9: `rsp_valid` is high for exactly one cycle, in the cycle after each accepted request (`req_valid` and `req_ready` both high), and is never high otherwise.
- R10: On an aligned access, the number of asserted bits of `mem_be` is 1, 2 or 4 for byte, halfword or word size.
- R11: The reserved size code 11 is treated as misaligned.
- R12: `req_ready` is low while `rst_n` is low and is high from the first clock edge after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_write | input | 1 | 1 store, 0 load |
| req_wdata | input | 32 | Store value, right-justified |
| req_sext | input | 1 | Sign-extend narrow loads |
| cfg_big_end | input | 1 | Byte order: 0 little, 1 big |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_be | output | 4 | Per-lane byte enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Read data, one cycle after `mem_en` |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Request was misaligned |
| rsp_data | output | 32 | Load result |

## Verification
On every cycle, the checker confirms several properties. It checks that a response follows each acceptance and appears at no other time. It checks that misaligned requests, decoded independently from address and size, produce no memory strobe or byte enable, and that they produce an error one cycle later. It also checks the enable count for each size and that loads never write.

Some behaviours only the bench scenarios can show: where each byte actually lands in both byte orders, correct sign and zero extension, and that memory survives rejected stores and loads intact. The bench shows these by comparing every load against a byte-addressed reference model.

// File: rtl/eau_pkg.sv
package eau_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // index of the most significant byte of a value of the given size
  function automatic logic [OFF_W-1:0] top_byte(input acc_size_e sz);
    case (sz)
      SZ_BYTE: top_byte = OFF_W'(0);
      SZ_HALF: top_byte = OFF_W'(1);
      default: top_byte = OFF_W'(LANES - 1);
    endcase
  endfunction
endpackage

// File: rtl/eau_align_chk.sv
module eau_align_chk
  import eau_pkg::*;
(
  input  logic [OFF_W-1:0] offset,
  input  acc_size_e        size,
  output logic             aligned,
  output logic [LANES-1:0] addr_mask
);
  always_comb begin
    aligned   = 1'b0;
    addr_mask = '0;
    case (size)
      SZ_BYTE: begin
        aligned   = 1'b1;
        addr_mask = LANES'(1) << offset;
      end
      SZ_HALF: begin
        aligned   = (offset[0] == 1'b0);
        addr_mask = LANES'(3) << offset;
      end
      SZ_WORD: begin
        aligned   = (offset == '0);
        addr_mask = '1;
      end
      default: begin
        aligned   = 1'b0;
        addr_mask = '0;
      end
    endcase
    if (!aligned) addr_mask = '0;
  end
endmodule

// File: rtl/eau_store_steer.sv
module eau_store_steer
  import eau_pkg::*;
(
  input  logic [OFF_W-1:0]  offset,
  input  acc_size_e         size,
  input  logic              big_end,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  addr_mask,
  output logic [LANES-1:0]  lane_be,
  output logic [DATA_W-1:0] lane_data
);
  logic [OFF_W-1:0] msb_idx;
  assign msb_idx = top_byte(size);

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [OFF_W-1:0] word_pos;   // byte-address offset carried by this lane
    logic [OFF_W-1:0] rel_pos;    // distance from the request address
    logic [OFF_W-1:0] val_idx;    // which byte of the value lands here

    always_comb begin
      word_pos = big_end ? OFF_W'(LANES - 1 - ln) : OFF_W'(ln);
      rel_pos  = word_pos - offset;
      val_idx  = big_end ? (msb_idx - rel_pos) : rel_pos;
    end

    assign lane_be[ln]          = addr_mask[word_pos];
    assign lane_data[ln*8 +: 8] = addr_mask[word_pos] ? wdata[val_idx*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/eau_load_merge.sv
module eau_load_merge
  import eau_pkg::*;
(
  input  logic [DATA_W-1:0] rdata,
  input  logic [OFF_W-1:0]  offset,
  input  acc_size_e         size,
  input  logic              big_end,
  input  logic              sext,
  output logic [DATA_W-1:0] value
);
  logic [OFF_W-1:0] msb_idx;
  logic [7:0]       vbyte [LANES];
  logic             fill;

  assign msb_idx = top_byte(size);

  for (genvar vb = 0; vb < LANES; vb++) begin : g_vbyte
    logic [OFF_W-1:0] word_pos;
    logic [OFF_W-1:0] lane_sel;
    always_comb begin
      word_pos = offset + (big_end ? (msb_idx - OFF_W'(vb)) : OFF_W'(vb));
      lane_sel = big_end ? (OFF_W'(LANES - 1) - word_pos) : word_pos;
    end
    assign vbyte[vb] = rdata[lane_sel*8 +: 8];
  end

  always_comb begin
    fill = 1'b0;
    case (size)
      SZ_BYTE: begin
        fill  = sext & vbyte[0][7];
        value = {{(DATA_W-8){fill}}, vbyte[0]};
      end
      SZ_HALF: begin
        fill  = sext & vbyte[1][7];
        value = {{(DATA_W-16){fill}}, vbyte[1], vbyte[0]};
      end
      default: value = {vbyte[3], vbyte[2], vbyte[1], vbyte[0]};
    endcase
  end
endmodule

// File: rtl/endian_access_unit.sv
module endian_access_unit
  import eau_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [1:0]              req_size,
  input  logic                    req_write,
  input  logic [31:0]             req_wdata,
  input  logic                    req_sext,
  input  logic                    cfg_big_end,
  output logic                    mem_en,
  output logic                    mem_we,
  output logic [ADDR_W-3:0]       mem_addr,
  output logic [3:0]              mem_be,
  output logic [31:0]             mem_wdata,
  input  logic [31:0]             mem_rdata,
  output logic                    rsp_valid,
  output logic                    rsp_err,
  output logic [31:0]             rsp_data
);
  localparam int unsigned WADDR_W = ADDR_W - OFF_W;

  acc_size_e         size_in;
  logic [OFF_W-1:0]  off_in;
  logic              accept;
  logic              aligned;
  logic [LANES-1:0]  addr_mask;
  logic [LANES-1:0]  lane_be;
  logic [DATA_W-1:0] lane_data;

  // state registers and their next values
  logic rdy_q, rdy_d;
  logic vld_q, vld_d;
  logic err_q, err_d;
  logic ld_q,  ld_d;
  logic [OFF_W-1:0] off_q;
  acc_size_e        size_q;
  logic             big_q;
  logic             sext_q;
  logic             meta_en;
  logic [DATA_W-1:0] merged;

  assign size_in = acc_size_e'(req_size);
  assign off_in  = req_addr[OFF_W-1:0];

  eau_align_chk u_align (
    .offset    (off_in),
    .size      (size_in),
    .aligned   (aligned),
    .addr_mask (addr_mask)
  );

  eau_store_steer u_steer (
    .offset    (off_in),
    .size      (size_in),
    .big_end   (cfg_big_end),
    .wdata     (req_wdata),
    .addr_mask (addr_mask),
    .lane_be   (lane_be),
    .lane_data (lane_data)
  );

  // request side
  always_comb begin
    accept    = req_valid & rdy_q;
    mem_en    = accept & aligned;
    mem_we    = mem_en & req_write;
    mem_addr  = req_addr[ADDR_W-1:OFF_W];
    mem_be    = mem_en ? lane_be : '0;
    mem_wdata = mem_we ? lane_data : '0;
  end

  // next state
  always_comb begin
    rdy_d   = 1'b1;
    vld_d   = accept;
    err_d   = accept & ~aligned;
    ld_d    = accept & aligned & ~req_write;
    meta_en = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
      ld_q  <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      vld_q <= vld_d;
      err_q <= err_d;
      ld_q  <= ld_d;
    end
  end

  // request attributes held for the response cycle; no reset needed
  always_ff @(posedge clk) begin
    if (meta_en) begin
      off_q  <= off_in;
      size_q <= size_in;
      big_q  <= cfg_big_end;
      sext_q <= req_sext;
    end
  end

  eau_load_merge u_merge (
    .rdata   (mem_rdata),
    .offset  (off_q),
    .size    (size_q),
    .big_end (big_q),
    .sext    (sext_q),
    .value   (merged)
  );

  assign req_ready = rdy_q;
  assign rsp_valid = vld_q;
  assign rsp_err   = err_q;
  assign rsp_data  = ld_q ? merged : '0;

  logic unused_waddr;
  assign unused_waddr = ^WADDR_W;
endmodule

// File: rtl/eau_checker.sv
module eau_checker #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              req_write,
  input logic              mem_en,
  input logic              mem_we,
  input logic [3:0]        mem_be,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [31:0]       rsp_data
);
  logic take;
  logic bad_align;
  logic [2:0] want_cnt;

  always_comb begin
    take      = req_valid && req_ready;
    bad_align = (req_size == 2'b11) ||
                (req_size == 2'b01 && req_addr[0]) ||
                (req_size == 2'b10 && req_addr[1:0] != 2'b00);
    want_cnt  = (req_size == 2'b00) ? 3'd1 : (req_size == 2'b01) ? 3'd2 : 3'd4;
  end

  a_r9_rsp_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid);

  a_r9_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !rsp_valid);

  a_r6_bad_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (take && bad_align) |-> (!mem_en && mem_be == 4'b0000));

  a_r6_bad_gives_err: assert property (@(posedge clk) disable iff (!rst_n)
    (take && bad_align) |=> rsp_err);

  a_r11_good_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !bad_align) |=> !rsp_err);

  a_r10_be_count: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> ($countones(mem_be) == 32'(want_cnt)));

  a_r8_load_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !req_write) |-> !mem_we);

  a_r7_err_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_data == 32'h0));
endmodule

bind endian_access_unit eau_checker #(.ADDR_W(ADDR_W)) u_eau_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_size  (req_size),
  .req_write (req_write),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_be    (mem_be),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_data  (rsp_data)
);

// File: tb/endian_access_unit_bench.sv
module endian_access_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int NBYTES     = 64;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0]        req_size;
  logic              req_write;
  logic [31:0]       req_wdata;
  logic              req_sext;
  logic              cfg_big_end;
  logic              mem_en;
  logic              mem_we;
  logic [ADDR_W-3:0] mem_addr;
  logic [3:0]        mem_be;
  logic [31:0]       mem_wdata;
  logic [31:0]       mem_rdata;
  logic              rsp_valid;
  logic              rsp_err;
  logic [31:0]       rsp_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] mem_words [NBYTES/4];
  logic [7:0]  ref_mem   [NBYTES];

  endian_access_unit #(.ADDR_W(ADDR_W)) u_endian_access_unit (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // lane memory with one-cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      mem_rdata <= mem_words[mem_addr[3:0]];
      for (int l = 0; l < 4; l++)
        if (mem_we && mem_be[l]) mem_words[mem_addr[3:0]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
  endfunction

  function automatic bit misaligned(input logic [ADDR_W-1:0] a, input logic [1:0] sz);
    return (sz == 2'b11) || (sz == 2'b01 && a[0]) || (sz == 2'b10 && a[1:0] != 2'b00);
  endfunction

  // address of byte i of the value, per R2 and R3
  function automatic int byte_addr(input int a, input int i, input int n, input bit big);
    return big ? a + n - 1 - i : a + i;
  endfunction

  function automatic logic [3:0] exp_be(input int a, input logic [1:0] sz, input bit big);
    logic [3:0] be = 4'b0;
    for (int k = 0; k < nbytes(sz); k++) begin
      int j = (a + k) % 4;
      be[big ? 3 - j : j] = 1'b1;
    end
    return be;
  endfunction

  function automatic logic [31:0] exp_load(input int a, input logic [1:0] sz, input bit big, input bit sx);
    logic [31:0] v = 32'h0;
    int n = nbytes(sz);
    for (int i = 0; i < n; i++) v[i*8 +: 8] = ref_mem[byte_addr(a, i, n, big) % NBYTES];
    if (sx && n == 1 && v[7])  v[31:8]  = 24'hFFFFFF;
    if (sx && n == 2 && v[15]) v[31:16] = 16'hFFFF;
    return v;
  endfunction

  task automatic clear_mem();
    for (int w = 0; w < NBYTES/4; w++) mem_words[w] = 32'h0;
    for (int b = 0; b < NBYTES; b++)   ref_mem[b]   = 8'h00;
  endtask

  // drive at a falling edge, check request side, then the response
  task automatic do_req(input int a, input logic [1:0] sz, input bit wr, input logic [31:0] wd,
                        input bit sx, input bit big);
    bit          mis = misaligned(ADDR_W'(a), sz);
    logic [31:0] exp = 32'h0;
    req_valid = 1'b1; req_addr = ADDR_W'(a); req_size = sz; req_write = wr;
    req_wdata = wd;   req_sext = sx;         cfg_big_end = big;
    #1;
    if (mis) begin
      check(!mem_en && mem_be == 4'b0, "R6 no access", {27'b0, mem_en, mem_be}, 32'h0);
    end else begin
      check(mem_en && mem_addr == ADDR_W'(a) >> 2, "R1 word address", 32'(mem_addr), 32'(a >> 2));
      check(mem_be == exp_be(a, sz, big), big ? "R3 lanes" : "R2 lanes", 32'(mem_be), 32'(exp_be(a, sz, big)));
      check(mem_we == wr, "R8 write strobe", 32'(mem_we), 32'(wr));
    end
    if (!wr && !mis) exp = exp_load(a, sz, big, sx);
    if (wr && !mis) begin
      int n = nbytes(sz);
      for (int i = 0; i < n; i++) ref_mem[byte_addr(a, i, n, big) % NBYTES] = wd[i*8 +: 8];
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid, "R9 response", 32'(rsp_valid), 32'h1);
    check(rsp_err == mis, mis ? "R6 error flag" : "R11 no error", 32'(rsp_err), 32'(mis));
    check(rsp_data == exp, sx ? "R7 sign extend" : (big ? "R3 load" : "R2 load"), rsp_data, exp);
  endtask

  task automatic idle_cycle();
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!rsp_valid, "R9 no stray response", 32'(rsp_valid), 32'h0);
  endtask

  task automatic run_phase(input bit big, input int count);
    clear_mem();
    // directed: word then each byte and halfword
    do_req(0, 2'b10, 1'b1, 32'h8123_44F5, 1'b0, big);
    for (int k = 0; k < 4; k++) do_req(k, 2'b00, 1'b0, 32'h0, 1'b1, big);
    do_req(0, 2'b01, 1'b0, 32'h0, 1'b1, big);
    do_req(2, 2'b01, 1'b0, 32'h0, 1'b0, big);
    do_req(2, 2'b01, 1'b0, 32'h0, 1'b1, big);
    do_req(0, 2'b10, 1'b0, 32'h0, 1'b0, big);
    // R4 R5 R11: rejected stores must leave memory intact
    do_req(1, 2'b01, 1'b1, 32'hDEAD_BEEF, 1'b0, big);
    do_req(2, 2'b10, 1'b1, 32'hDEAD_BEEF, 1'b0, big);
    do_req(0, 2'b11, 1'b1, 32'hDEAD_BEEF, 1'b0, big);
    do_req(3, 2'b10, 1'b0, 32'h0, 1'b0, big);
    do_req(0, 2'b10, 1'b0, 32'h0, 1'b0, big);
    idle_cycle();
    for (int t = 0; t < count; t++) begin
      int          a  = int'($urandom_range(0, NBYTES - 1));
      logic [1:0]  sz = 2'($urandom_range(0, 3));
      bit          wr = bit'($urandom_range(0, 1));
      logic [31:0] wd = $urandom;
      bit          sx = bit'($urandom_range(0, 1));
      if (sz == 2'b11 && $urandom_range(0, 3) != 0) sz = 2'b10;
      do_req(a, sz, wr, wd, sx, big);
      if ($urandom_range(0, 3) == 0) idle_cycle();
    end
    // final readback of every word
    for (int w = 0; w < NBYTES/4; w++) do_req(w * 4, 2'b10, 1'b0, 32'h0, 1'b0, big);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R9 actual=%h expected=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = 2'b00;
    req_write = 1'b0; req_wdata = '0; req_sext = 1'b0; cfg_big_end = 1'b0;
    mem_rdata = '0;
    clear_mem();
    repeat (3) @(negedge clk);
    check(!req_ready, "R12 ready in reset", 32'(req_ready), 32'h0);
    check(!rsp_valid, "R9 idle in reset", 32'(rsp_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R12 ready after reset", 32'(req_ready), 32'h1);
    run_phase(1'b0, 600);
    run_phase(1'b1, 600);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule